// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This block watches the hot-plug-detect line of a display output and tells the host when a sink is attached or removed. The raw pin is first brought into the local clock domain by a two-stage synchroniser. A debounce filter then accepts a new level only after the pin has held it for a programmable number of ticks of a prescaled timebase. The accepted level can be read as a status bit.

Each accepted rising edge of the filtered level sets its own sticky event flag, and so does each accepted falling edge. A third flag follows an interrupt request from the attached display controller. All three flags share one status register, one write-one-to-clear register and one active-high enable mask. The single interrupt output is a level: it is high while any flag that is set also has its enable bit set.

The host reaches the block through a word-addressed port with a write strobe and a combinational read path. Register words are 0 for status (read only), 1 for clear (write only, reads zero), 2 for mask, 3 for the filtered level and 4 for the filter setup.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset the status word, the mask word and the interrupt output are all zero. The level word reads 0 (disconnected). The filter word reads 0xA0A0.
- R2: With prescale 0 and count C, a change of the raw pin held steady reaches the level word at the (C+2)th rising clock edge after the change, and not before.
- R3: A raw pulse that is shorter than the count, measured in ticks, leaves the level word and the status word unchanged.
- R4: An accepted rise of the filtered level sets status bit 1, and an accepted fall sets status bit 2. Each bit is set one clock edge after the level word changes. Both bits stay set until they are cleared.
- R5: Writing the clear word clears every status bit that has a 1 in the written data. Bits written with 0 keep their value.
- R6: When a source sets a status bit in the same cycle as a clear of that bit, the bit stays set.
- R7: The interrupt output is high exactly when some status bit is set and its bit in the mask word is also 1. It falls once the matching status bits are cleared or masked.
- R8: When the controller interrupt input is high at a clock edge, status bit 0 is set at that edge. Bit 0 is cleared and masked in the same way as the other bits.
- R9: The level word reads nonzero (bit 0 = 1) while the filtered level says a sink is connected.
- R10: In the filter word, bits 15:12 hold the prescale P and bits 7:0 hold the count C. A tick occurs once every P+1 cycles, and a count of 0 acts as 1. With P=1 and C=2, the level word has not changed 4 edges after a raw change and has changed by 6 edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hpd_raw_i | input | 1 | Raw hot-plug-detect pin, asynchronous |
| core_irq_i | input | 1 | Interrupt request from the display controller |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Merged interrupt, level |

## Verification
The timing of the results is fixed. With a one-cycle tick, a raw change reaches the level word at the (C+2)th edge: two synchroniser edges plus C counting edges. The matching status bit follows one edge later. A register write or a core request takes effect at the edge that samples it. The interrupt output follows the status and mask registers with no extra delay. The bench drives inputs on falling edges and counts rising edges one at a time. It reads the registers just after a falling edge, checking both the last cycle before each result and the first cycle after it. When a prescale greater than 0 makes the tick phase uncertain, the bench checks the earliest and latest bounds instead.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  localparam int unsigned AW      = 3;
  localparam int unsigned NSRC    = 3;
  localparam int unsigned SRC_CORE = 0;
  localparam int unsigned SRC_RISE = 1;
  localparam int unsigned SRC_FALL = 2;
  localparam logic [AW-1:0] A_STAT = 3'd0;
  localparam logic [AW-1:0] A_CLR  = 3'd1;
  localparam logic [AW-1:0] A_MASK = 3'd2;
  localparam logic [AW-1:0] A_LVL  = 3'd3;
  localparam logic [AW-1:0] A_FILT = 3'd4;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= d_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_filter.sv
module hpd_filter #(
  parameter int unsigned PW = 4,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_i,
  input  logic [PW-1:0] pre_i,
  input  logic [CW-1:0] cnt_i,
  output logic          lvl_o,
  output logic          rise_o,
  output logic          fall_o
);
  logic [PW-1:0] pcnt_q;
  logic [CW-1:0] scnt_q;
  logic [CW-1:0] need;
  logic          tick;

  assign tick = (pcnt_q >= pre_i);
  assign need = (cnt_i == '0) ? CW'(1) : cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else if (tick) pcnt_q <= '0;
    else pcnt_q <= pcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o  <= 1'b0;
      scnt_q <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (in_i == lvl_o) begin
        scnt_q <= '0;
      end else if (tick) begin
        if (scnt_q >= need - 1'b1) begin
          lvl_o  <= in_i;
          scnt_q <= '0;
          rise_o <= in_i;
          fall_o <= ~in_i;
        end else begin
          scnt_q <= scnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hpd_evt_regs.sv
module hpd_evt_regs #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_o[g] <= 1'b0;
      else if (set_i[g]) status_o[g] <= 1'b1;  // set beats clear
      else if (clr_we_i && clr_i[g]) status_o[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else if (mask_we_i) mask_o <= mask_i;
  end

  assign irq_o = |(status_o & mask_o);
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned PW      = 4,
  parameter int unsigned CW      = 8,
  parameter int unsigned PRE_LSB = 12,
  parameter logic [PW-1:0] PRE_RST = 4'hA,
  parameter logic [CW-1:0] CNT_RST = 8'hA0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hpd_raw_i,
  input  logic          core_irq_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic            hpd_s;
  logic            lvl, rise_p, fall_p;
  logic [PW-1:0]   pre_q;
  logic [CW-1:0]   cnt_q;
  logic [NSRC-1:0] set_v, status_q, mask_q;
  logic            clr_we, mask_we, filt_we;
  logic            unused_wdata;

  assign clr_we  = we_i && (addr_i == A_CLR);
  assign mask_we = we_i && (addr_i == A_MASK);
  assign filt_we = we_i && (addr_i == A_FILT);
  assign unused_wdata = ^{wdata_i[DW-1:PRE_LSB+PW], wdata_i[PRE_LSB-1:CW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= PRE_RST;
      cnt_q <= CNT_RST;
    end else if (filt_we) begin
      pre_q <= wdata_i[PRE_LSB +: PW];
      cnt_q <= wdata_i[CW-1:0];
    end
  end

  hpd_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hpd_raw_i), .q_o(hpd_s)
  );

  hpd_filter #(.PW(PW), .CW(CW)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_i(hpd_s), .pre_i(pre_q), .cnt_i(cnt_q),
    .lvl_o(lvl), .rise_o(rise_p), .fall_o(fall_p)
  );

  always_comb begin
    set_v           = '0;
    set_v[SRC_CORE] = core_irq_i;
    set_v[SRC_RISE] = rise_p;
    set_v[SRC_FALL] = fall_p;
  end

  hpd_evt_regs #(.N(NSRC)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v),
    .clr_we_i(clr_we), .clr_i(wdata_i[NSRC-1:0]),
    .mask_we_i(mask_we), .mask_i(wdata_i[NSRC-1:0]),
    .status_o(status_q), .mask_o(mask_q), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_STAT: rdata_o[NSRC-1:0] = status_q;
      A_MASK: rdata_o[NSRC-1:0] = mask_q;
      A_LVL:  rdata_o[0] = lvl;
      A_FILT: begin
        rdata_o[PRE_LSB +: PW] = pre_q;
        rdata_o[CW-1:0]        = cnt_q;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hpd_irq_unit_chk.sv
module hpd_irq_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_irq_i,
  input logic       irq_o,
  input logic       clr_we,
  input logic [2:0] clr_bits,
  input logic [2:0] status,
  input logic [2:0] mask,
  input logic       lvl,
  input logic       rise_p,
  input logic       fall_p
);
  assert_level_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl != $past(lvl)) |-> (rise_p || fall_p));
  assert_edge_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_p, fall_p}));
  assert_rise_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_p |=> status[1]);
  assert_fall_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_p |=> status[2]);
  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we && clr_bits[1] && !rise_p) |=> !status[1]);
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[2] && !(clr_we && clr_bits[2])) |=> status[2]);
  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_irq_i && clr_we && clr_bits[0]) |=> status[0]);
  assert_mask_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == 3'b000) |-> !irq_o);
  assert_core_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_irq_i |=> status[0]);
endmodule

bind hpd_irq_unit hpd_irq_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .core_irq_i(core_irq_i), .irq_o(irq_o),
  .clr_we(clr_we), .clr_bits(wdata_i[2:0]), .status(status_q), .mask(mask_q),
  .lvl(lvl), .rise_p(rise_p), .fall_p(fall_p)
);

// File: tb/tb_hpd_irq_unit.sv
module tb_hpd_irq_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hpd_raw_i = 1'b0;
  logic        core_irq_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hpd_irq_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .hpd_raw_i(hpd_raw_i), .core_irq_i(core_irq_i),
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk);
    #1 we_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 status", d, 32'h0);
    rd(3'd2, d); chk("R1 mask", d, 32'h0);
    rd(3'd3, d); chk("R1 level", d, 32'h0);
    rd(3'd4, d); chk("R1 filter default", d, 32'h0000A0A0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_rise;
    logic [31:0] d;
    wr(3'd4, 32'h0000_0004);
    hpd_raw_i = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 5) begin rd(3'd3, d); chk("R2 level before C+2", d, 32'h0); end
      if (k == 6) begin
        rd(3'd3, d); chk("R2 R9 level at C+2", d, 32'h1);
        rd(3'd0, d); chk("R4 rise not yet", d, 32'h0);
      end
      if (k == 7) begin rd(3'd0, d); chk("R4 rise sets bit1", d, 32'h2); end
    end
  endtask

  task automatic t_fall;
    logic [31:0] d;
    hpd_raw_i = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 5) begin rd(3'd3, d); chk("R2 fall level before", d, 32'h1); end
      if (k == 6) begin rd(3'd3, d); chk("R2 fall level at C+2", d, 32'h0); end
      if (k == 7) begin rd(3'd0, d); chk("R4 fall sets bit2, bit1 sticky", d, 32'h6); end
    end
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(3'd1, 32'h0);
    rd(3'd0, d); chk("R5 zero write no effect", d, 32'h6);
    wr(3'd1, 32'h2);
    rd(3'd0, d); chk("R5 clear bit1 only", d, 32'h4);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    chk("R7 irq masked off", {31'b0, irq_o}, 32'h0);
    wr(3'd2, 32'h2);
    chk("R7 irq other bit enabled", {31'b0, irq_o}, 32'h0);
    wr(3'd2, 32'h4);
    rd(3'd2, d); chk("R7 mask readback", d, 32'h4);
    chk("R7 irq enabled", {31'b0, irq_o}, 32'h1);
    wr(3'd1, 32'h4);
    chk("R7 irq drops after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_glitch;
    logic [31:0] d;
    hpd_raw_i = 1'b1;
    repeat (3) @(negedge clk);
    hpd_raw_i = 1'b0;
    repeat (12) @(negedge clk);
    rd(3'd3, d); chk("R3 glitch level", d, 32'h0);
    rd(3'd0, d); chk("R3 glitch status", d, 32'h0);
  endtask

  task automatic t_core;
    logic [31:0] d;
    wr(3'd2, 32'h1);
    core_irq_i = 1'b1;
    @(posedge clk); #1 core_irq_i = 1'b0;
    @(negedge clk);
    rd(3'd0, d); chk("R8 core sets bit0", d, 32'h1);
    chk("R8 core irq", {31'b0, irq_o}, 32'h1);
    wr(3'd1, 32'h1);
    rd(3'd0, d); chk("R8 core clear", d, 32'h0);
    core_irq_i = 1'b1;
    wr(3'd1, 32'h1);
    rd(3'd0, d); chk("R6 set wins over clear", d, 32'h1);
    core_irq_i = 1'b0;
    wr(3'd1, 32'h1);
    rd(3'd0, d); chk("R6 clear after source drops", d, 32'h0);
    chk("R7 irq low at end", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(3'd4, 32'h0000_1002);
    rd(3'd4, d); chk("R10 filter readback", d, 32'h00001002);
    hpd_raw_i = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 4) begin rd(3'd3, d); chk("R10 not before 4 edges", d, 32'h0); end
      if (k == 6) begin rd(3'd3, d); chk("R10 changed by 6 edges", d, 32'h1); end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_clear();
    t_mask();
    t_glitch();
    t_core();
    t_prescale();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule